// File: doc/BRIEF.md
# Word-oriented stream cipher keystream generator

This block turns a 128-bit key and a 128-bit initialisation vector into a sequence of 32-bit keystream words. Its state is a sixteen-stage linear feedback shift register with 32-bit stages and a nonlinear finite state machine with three 32-bit registers. The nonlinear part uses two 32-bit substitution boxes. Each box has a byte substitution followed by a column mix over GF(2^8). The linear part uses two byte-to-word multiply and divide maps over GF(2^8) with reduction constant 0xA9.

A request on `start_i` loads key and IV into the state. The block then runs 32 warm-up steps in which the nonlinear output feeds back into the shift register. One more step follows whose output is thrown away. After that the block delivers `count_i` words through a valid/ready handshake, one word per accepted transfer. Every step takes one clock cycle. A consumer that holds `ks_ready_i` low freezes the whole state.

Top module: `wsk_keygen`

## Requirements
- R1: After reset `busy_o`, `done_o` and `ks_valid_o` are low.
- R2: Key word j is `key_i[32*j +: 32]` and IV word j is `iv_i[32*j +: 32]`. The state loads as follows: stages 0..3 take the inverted key words 0..3, stages 4..7 take key words 0..3, stages 8..11 take the inverted key words 0..3, and stages 12..15 take key words 0..3. IV word 0 is XORed into stage 15, IV word 1 into stage 12, IV word 2 into stage 10 and IV word 3 into stage 9. The three nonlinear registers start at zero. The first word delivered is bit-exact with a model built on this loading.
- R3: Warm-up is exactly 32 steps with the nonlinear output XORed into the shift feedback, followed by one discarded step without that XOR. `ks_valid_o` first goes high after the 34th rising edge, counting the edge that accepts `start_i`.
- R4: Each delivered word is F XOR stage 0, where F = ((stage15 + R1) mod 2^32) XOR R2. After the word is delivered, the shift register advances without F in its feedback. Words 1 to 8 are bit-exact for several random keys and IVs.
- R5: A run of 100 words stays bit-exact to the end.
- R6: While `ks_valid_o` is high and `ks_ready_i` is low, `ks_data_o` and the internal state hold, so stalls never change the delivered sequence.
- R7: `start_i` has no effect unless the block is idle. This holds even in the cycle in which the last word is accepted.
- R8: The cycle after the count-th word is accepted, `ks_valid_o` and `busy_o` are low and `done_o` is high. `done_o` stays high until the next accepted start clears it.
- R9: With `count_i` equal to 0 no word is offered, and `done_o` rises after the 34th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load key/IV and begin; sampled only when idle |
| key_i | input | 128 | Four 32-bit key words, word j at bits 32j+31..32j |
| iv_i | input | 128 | Four 32-bit IV words, same packing |
| count_i | input | CNT_W | Number of words to deliver |
| ks_ready_i | input | 1 | Consumer accepts the current word |
| ks_valid_o | output | 1 | A keystream word is offered |
| ks_data_o | output | 32 | Keystream word |
| busy_o | output | 1 | Loading, warming up or delivering |
| done_o | output | 1 | Requested words all accepted |

## Verification
Two events can coincide in one cycle: a new start request and the acceptance of the final word. The bench raises `start_i` with an inverted key, an inverted IV and a larger count during random cycles of a delivery. It also holds `start_i` high through the cycle in which the last word is taken. The request must change nothing. Every word must still match the model for the original key, and the following cycle must show the block idle with `done_o` set, with no second warm-up started. Random back-pressure also places stalls on the first and last words of each run, so the held state is checked against the model word by word.

// File: rtl/wsk_pkg.sv
`timescale 1ns/1ps
package wsk_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LANES     = WORD_W / BYTE_W;
  localparam int unsigned STAGES    = 16;
  localparam int unsigned KEY_WORDS = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_PRIME, PH_RUN} phase_e;

  localparam byte_t RED_R  = 8'h1b;  // field for the first box
  localparam byte_t RED_Q  = 8'h69;  // field for the second box
  localparam byte_t RED_A  = 8'ha9;  // field for the shift-register maps
  localparam byte_t AFF_R  = 8'h63;
  localparam byte_t AFF_Q  = 8'h25;

  function automatic byte_t xt(byte_t v, byte_t red);
    return v[BYTE_W-1] ? (byte_t'(v << 1) ^ red) : byte_t'(v << 1);
  endfunction

  function automatic byte_t xt_pow(byte_t v, int unsigned n, byte_t red);
    byte_t a = v;
    for (int unsigned i = 0; i < 256; i++)
      if (i < n) a = xt(a, red);
    return a;
  endfunction

  function automatic byte_t gmul(byte_t a, byte_t b, byte_t red);
    byte_t acc = '0;
    byte_t p   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xt(p, red);
    end
    return acc;
  endfunction

  function automatic byte_t rotl(byte_t v, int n);
    return byte_t'(v << n) | byte_t'(v >> (BYTE_W - n));
  endfunction

  // inverse as x^254 by a square chain, then the affine layer
  function automatic byte_t sr_byte(byte_t x);
    byte_t p   = x;
    byte_t inv = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      p   = gmul(p, p, RED_R);
      inv = gmul(inv, p, RED_R);
    end
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ AFF_R;
  endfunction

  // degree-49 permutation polynomial, odd terms 1,9,13,15,33,41,45,47,49
  function automatic byte_t sq_byte(byte_t x);
    byte_t x2, x4, x8, x9, x13, x15, x16, x32, x33, x41, x45, x47, x49;
    x2  = gmul(x, x, RED_Q);
    x4  = gmul(x2, x2, RED_Q);
    x8  = gmul(x4, x4, RED_Q);
    x9  = gmul(x8, x, RED_Q);
    x13 = gmul(x9, x4, RED_Q);
    x15 = gmul(x13, x2, RED_Q);
    x16 = gmul(x8, x8, RED_Q);
    x32 = gmul(x16, x16, RED_Q);
    x33 = gmul(x32, x, RED_Q);
    x41 = gmul(x33, x8, RED_Q);
    x45 = gmul(x41, x4, RED_Q);
    x47 = gmul(x45, x2, RED_Q);
    x49 = gmul(x47, x2, RED_Q);
    return x ^ x9 ^ x13 ^ x15 ^ x33 ^ x41 ^ x45 ^ x47 ^ x49 ^ AFF_Q;
  endfunction
endpackage

// File: rtl/wsk_sbox_unit.sv
`timescale 1ns/1ps
module wsk_sbox_unit
  import wsk_pkg::*;
#(
  parameter bit USE_Q = 1'b0
) (
  input  word_t w_i,
  output word_t w_o
);
  localparam byte_t RED = USE_Q ? RED_Q : RED_R;

  byte_t sub [LANES];
  byte_t dbl [LANES];

  // lane 0 is the most significant byte
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int unsigned HI = WORD_W - 1 - BYTE_W * j;
    localparam int unsigned JM = (j + LANES - 1) % LANES;
    localparam int unsigned J1 = (j + 1) % LANES;
    localparam int unsigned J2 = (j + 2) % LANES;
    if (USE_Q) begin : g_q
      assign sub[j] = sq_byte(w_i[HI -: BYTE_W]);
    end else begin : g_r
      assign sub[j] = sr_byte(w_i[HI -: BYTE_W]);
    end
    assign dbl[j] = xt(sub[j], RED);
    assign w_o[HI -: BYTE_W] = dbl[j] ^ dbl[JM] ^ sub[JM] ^ sub[J1] ^ sub[J2];
  end
endmodule

// File: rtl/wsk_alpha_map.sv
`timescale 1ns/1ps
module wsk_alpha_map
  import wsk_pkg::*;
#(
  parameter int unsigned EXP0 = 23,   // most significant lane
  parameter int unsigned EXP1 = 245,
  parameter int unsigned EXP2 = 48,
  parameter int unsigned EXP3 = 239
) (
  input  byte_t c_i,
  output word_t w_o
);
  localparam int unsigned COLS_W = WORD_W * BYTE_W;

  // map is GF(2)-linear: precompute the image of each input bit
  function automatic logic [COLS_W-1:0] build_cols();
    logic [COLS_W-1:0] cols;
    int unsigned e;
    cols = '0;
    for (int j = 0; j < int'(LANES); j++) begin
      e = (j == 0) ? EXP0 : (j == 1) ? EXP1 : (j == 2) ? EXP2 : EXP3;
      for (int b = 0; b < int'(BYTE_W); b++)
        cols[(j*BYTE_W+b)*BYTE_W +: BYTE_W] = xt_pow(byte_t'(1 << b), e, RED_A);
    end
    return cols;
  endfunction

  localparam logic [COLS_W-1:0] COLS = build_cols();

  always_comb begin
    w_o = '0;
    for (int j = 0; j < int'(LANES); j++)
      for (int b = 0; b < int'(BYTE_W); b++)
        if (c_i[b])
          w_o[WORD_W-1-BYTE_W*j -: BYTE_W] = w_o[WORD_W-1-BYTE_W*j -: BYTE_W] ^
                                             COLS[(j*BYTE_W+b)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/wsk_fsm_core.sv
`timescale 1ns/1ps
module wsk_fsm_core
  import wsk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  step_i,
  input  word_t s15_i,
  input  word_t s5_i,
  output word_t f_o
);
  word_t r1_q, r2_q, r3_q;
  word_t s1_w, s2_w;

  wsk_sbox_unit #(.USE_Q(1'b0)) u_box_r (.w_i(r1_q), .w_o(s1_w));
  wsk_sbox_unit #(.USE_Q(1'b1)) u_box_q (.w_i(r2_q), .w_o(s2_w));

  assign f_o = (s15_i + r1_q) ^ r2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q <= '0;
      r2_q <= '0;
      r3_q <= '0;
    end else if (clear_i) begin
      r1_q <= '0;
      r2_q <= '0;
      r3_q <= '0;
    end else if (step_i) begin
      r1_q <= r2_q + (r3_q ^ s5_i);
      r2_q <= s1_w;
      r3_q <= s2_w;
    end
  end

  // registers cleared on load: the first output is the top stage itself
  p_zero_after_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> f_o == s15_i);
endmodule

// File: rtl/wsk_lfsr_bank.sv
`timescale 1ns/1ps
module wsk_lfsr_bank
  import wsk_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     step_i,
  input  logic                     fb_en_i,
  input  logic [STAGES*WORD_W-1:0] seed_i,
  input  word_t                    f_i,
  output word_t                    s0_o,
  output word_t                    s5_o,
  output word_t                    s15_o
);
  localparam int unsigned TAP_A = 2;
  localparam int unsigned TAP_B = 11;
  localparam int unsigned TAP_M = 5;
  localparam int unsigned TOP   = STAGES - 1;

  word_t stg_q [STAGES];
  word_t mul_w, div_w, fb_w;

  wsk_alpha_map #(.EXP0(23), .EXP1(245), .EXP2(48), .EXP3(239)) u_mul (
    .c_i(stg_q[0][WORD_W-1 -: BYTE_W]),
    .w_o(mul_w)
  );
  wsk_alpha_map #(.EXP0(16), .EXP1(39), .EXP2(6), .EXP3(64)) u_div (
    .c_i(stg_q[TAP_B][BYTE_W-1:0]),
    .w_o(div_w)
  );

  assign fb_w = {stg_q[0][WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^ mul_w ^ stg_q[TAP_A] ^
                {{BYTE_W{1'b0}}, stg_q[TAP_B][WORD_W-1:BYTE_W]} ^ div_w ^
                (fb_en_i ? f_i : '0);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    word_t nxt_w;
    if (i == TOP) begin : g_top
      assign nxt_w = fb_w;
    end else begin : g_mid
      assign nxt_w = stg_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stg_q[i] <= '0;
      else if (load_i)  stg_q[i] <= seed_i[i*WORD_W +: WORD_W];
      else if (step_i)  stg_q[i] <= nxt_w;
    end
  end

  assign s0_o  = stg_q[0];
  assign s5_o  = stg_q[TAP_M];
  assign s15_o = stg_q[TOP];

  p_shift_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> s0_o == $past(stg_q[1]));
endmodule

// File: rtl/wsk_keygen.sv
`timescale 1ns/1ps
module wsk_keygen
  import wsk_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned INIT_STEPS = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [KEY_WORDS*WORD_W-1:0] key_i,
  input  logic [KEY_WORDS*WORD_W-1:0] iv_i,
  input  logic [CNT_W-1:0]            count_i,
  input  logic                        ks_ready_i,
  output logic                        ks_valid_o,
  output logic [WORD_W-1:0]           ks_data_o,
  output logic                        busy_o,
  output logic                        done_o
);
  localparam int unsigned STEP_W    = $clog2(INIT_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(INIT_STEPS - 1);

  phase_e             st_q;
  logic [STEP_W-1:0]  step_q;
  logic [CNT_W-1:0]   left_q;
  logic               done_q;

  logic                     load_w, step_w, fb_w, fire_w;
  logic [STAGES*WORD_W-1:0] seed_w;
  word_t                    f_w, s0_w, s5_w, s15_w;

  // seed: groups of four stages, groups 0 and 2 inverted, IV on fixed stages
  for (genvar i = 0; i < STAGES; i++) begin : g_seed
    localparam int unsigned KI  = i % KEY_WORDS;
    localparam bit          INV = ((i / KEY_WORDS) % 2) == 0;
    localparam int          IVI = (i == 15) ? 0 : (i == 12) ? 1 : (i == 10) ? 2 : (i == 9) ? 3 : -1;
    word_t base_w;
    assign base_w = key_i[KI*WORD_W +: WORD_W] ^ {WORD_W{INV}};
    if (IVI >= 0) begin : g_iv
      assign seed_w[i*WORD_W +: WORD_W] = base_w ^ iv_i[IVI*WORD_W +: WORD_W];
    end else begin : g_key
      assign seed_w[i*WORD_W +: WORD_W] = base_w;
    end
  end

  assign load_w = (st_q == PH_IDLE) && start_i;
  assign fire_w = ks_valid_o && ks_ready_i;
  assign step_w = (st_q == PH_INIT) || (st_q == PH_PRIME) || fire_w;
  assign fb_w   = (st_q == PH_INIT);

  wsk_lfsr_bank u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_w),
    .step_i  (step_w),
    .fb_en_i (fb_w),
    .seed_i  (seed_w),
    .f_i     (f_w),
    .s0_o    (s0_w),
    .s5_o    (s5_w),
    .s15_o   (s15_w)
  );

  wsk_fsm_core u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_w),
    .step_i  (step_w),
    .s15_i   (s15_w),
    .s5_i    (s5_w),
    .f_o     (f_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      step_q <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (st_q)
        PH_IDLE: if (start_i) begin
          st_q   <= PH_INIT;
          step_q <= '0;
          left_q <= count_i;
          done_q <= 1'b0;
        end
        PH_INIT: begin
          step_q <= step_q + 1'b1;
          if (step_q == LAST_STEP) st_q <= PH_PRIME;
        end
        PH_PRIME: begin
          if (left_q == '0) begin
            st_q   <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= PH_RUN;
          end
        end
        PH_RUN: if (fire_w) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            st_q   <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign ks_valid_o = (st_q == PH_RUN);
  assign ks_data_o  = f_w ^ s0_w;
  assign busy_o     = (st_q != PH_IDLE);
  assign done_o     = done_q;

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o && !ks_ready_i |=> ks_valid_o && $stable(ks_data_o));

  p_init_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_INIT) && (step_q != LAST_STEP) |=> (st_q == PH_INIT) && !ks_valid_o);

  p_busy_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !fire_w |=> left_q == $past(left_q));

  p_accept_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_w |=> done_o || (left_q == $past(left_q) - CNT_W'(1)));

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !busy_o && !ks_valid_o);
endmodule

// File: tb/wsk_keygen_test.sv
`timescale 1ns/1ps
module wsk_keygen_test;
  localparam int CNT_W = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          start_i;
  logic [127:0]  key_i, iv_i;
  logic [CNT_W-1:0] count_i;
  logic          ks_ready_i;
  logic          ks_valid_o;
  logic [31:0]   ks_data_o;
  logic          busy_o, done_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  wsk_keygen #(.CNT_W(CNT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .key_i(key_i), .iv_i(iv_i),
    .count_i(count_i), .ks_ready_i(ks_ready_i), .ks_valid_o(ks_valid_o),
    .ks_data_o(ks_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  // ---------------- independent model ----------------
  logic [7:0]  t_sr [256];
  logic [7:0]  t_sq [256];
  logic [31:0] m_s  [16];
  logic [31:0] m_r1, m_r2, m_r3;
  logic [31:0] exp_w [128];

  function automatic logic [7:0] b_xt(logic [7:0] v, logic [7:0] c);
    logic [7:0] sh = {v[6:0], 1'b0};
    return v[7] ? (sh ^ c) : sh;
  endfunction

  function automatic logic [7:0] b_pow(logic [7:0] v, int n, logic [7:0] c);
    logic [7:0] a = v;
    int k = n;
    while (k > 0) begin a = b_xt(a, c); k--; end
    return a;
  endfunction

  function automatic logic [7:0] b_mul(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [7:0] acc = 8'h00;
    logic [7:0] p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= p;
      p = b_xt(p, c);
    end
    return acc;
  endfunction

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, o, p, acc;
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (b_mul(8'(x), 8'(y), 8'h1b) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      t_sr[x] = o;
      acc = 8'h00;
      p = 8'(x);
      for (int e = 1; e <= 49; e++) begin
        if (e == 1 || e == 9 || e == 13 || e == 15 || e == 33 || e == 41 || e == 45 || e == 47 || e == 49)
          acc ^= p;
        p = b_mul(p, 8'(x), 8'h69);
      end
      t_sq[x] = acc ^ 8'h25;
    end
  endtask

  function automatic logic [31:0] b_box(logic [31:0] w, bit q);
    logic [7:0] a0, a1, a2, a3, c, d0, d1, d2, d3;
    c  = q ? 8'h69 : 8'h1b;
    a0 = q ? t_sq[w[31:24]] : t_sr[w[31:24]];
    a1 = q ? t_sq[w[23:16]] : t_sr[w[23:16]];
    a2 = q ? t_sq[w[15:8]]  : t_sr[w[15:8]];
    a3 = q ? t_sq[w[7:0]]   : t_sr[w[7:0]];
    d0 = b_xt(a0, c); d1 = b_xt(a1, c); d2 = b_xt(a2, c); d3 = b_xt(a3, c);
    return {d0 ^ a1 ^ a2 ^ d3 ^ a3,
            d0 ^ a0 ^ d1 ^ a2 ^ a3,
            a0 ^ d1 ^ a1 ^ d2 ^ a3,
            a0 ^ a1 ^ d2 ^ a2 ^ d3};
  endfunction

  function automatic logic [31:0] b_alpha(logic [7:0] c);
    return {b_pow(c, 23, 8'ha9), b_pow(c, 245, 8'ha9), b_pow(c, 48, 8'ha9), b_pow(c, 239, 8'ha9)};
  endfunction

  function automatic logic [31:0] b_dalpha(logic [7:0] c);
    return {b_pow(c, 16, 8'ha9), b_pow(c, 39, 8'ha9), b_pow(c, 6, 8'ha9), b_pow(c, 64, 8'ha9)};
  endfunction

  task automatic m_fsm(output logic [31:0] f);
    logic [31:0] r;
    f = (m_s[15] + m_r1) ^ m_r2;
    r = m_r2 + (m_r3 ^ m_s[5]);
    m_r3 = b_box(m_r2, 1'b1);
    m_r2 = b_box(m_r1, 1'b0);
    m_r1 = r;
  endtask

  task automatic m_lfsr(input logic [31:0] f, input bit use_f);
    logic [31:0] v;
    v = {m_s[0][23:0], 8'h00} ^ b_alpha(m_s[0][31:24]) ^ m_s[2] ^
        {8'h00, m_s[11][31:8]} ^ b_dalpha(m_s[11][7:0]) ^ (use_f ? f : 32'h0);
    for (int i = 0; i < 15; i++) m_s[i] = m_s[i+1];
    m_s[15] = v;
  endtask

  task automatic model_gen(input logic [127:0] k, input logic [127:0] v, input int n);
    logic [31:0] kw [4];
    logic [31:0] vw [4];
    logic [31:0] f;
    for (int j = 0; j < 4; j++) begin kw[j] = k[32*j +: 32]; vw[j] = v[32*j +: 32]; end
    for (int j = 0; j < 4; j++) begin
      m_s[j]      = ~kw[j];
      m_s[4 + j]  =  kw[j];
      m_s[8 + j]  = ~kw[j];
      m_s[12 + j] =  kw[j];
    end
    m_s[15] ^= vw[0];
    m_s[12] ^= vw[1];
    m_s[10] ^= vw[2];
    m_s[9]  ^= vw[3];
    m_r1 = 0; m_r2 = 0; m_r3 = 0;
    for (int i = 0; i < 32; i++) begin m_fsm(f); m_lfsr(f, 1'b1); end
    m_fsm(f);
    m_lfsr(f, 1'b0);
    for (int t = 0; t < n; t++) begin
      m_fsm(f);
      exp_w[t] = f ^ m_s[0];
      m_lfsr(f, 1'b0);
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_case(input logic [127:0] k, input logic [127:0] v, input int n,
                          input bit stall, input bit poke);
    int cyc, idx;
    bit rdy, stalled;
    string tag;
    model_gen(k, v, n);
    @(negedge clk_i);
    key_i = k; iv_i = v; count_i = CNT_W'(n); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R8 done cleared by start", 32'(done_o), 32'h0);
    cyc = 1;
    while (!ks_valid_o && cyc < 60) begin @(negedge clk_i); cyc++; end
    chk(cyc == 34, "R3 first valid edge", 32'(cyc), 32'd34);
    idx = 0;
    stalled = 1'b0;
    while (idx < n) begin
      if (stalled)        tag = "R6 held word";
      else if (idx == 0)  tag = "R2 first word";
      else if (n > 8)     tag = "R5 long run word";
      else                tag = "R4 word";
      if (poke) tag = "R7 start while busy";
      chk(ks_valid_o && ks_data_o == exp_w[idx], tag, ks_data_o, exp_w[idx]);
      rdy = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (poke) begin
        start_i = (idx == n - 1) ? 1'b1 : 1'($urandom_range(0, 1));
        key_i = ~k; iv_i = ~v; count_i = CNT_W'(n + 3);
      end
      ks_ready_i = rdy;
      if (rdy) idx++;
      stalled = !rdy;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    ks_ready_i = 1'b0;
    chk(!ks_valid_o && done_o && !busy_o, poke ? "R7 idle after last" : "R8 done after last",
        {29'h0, ks_valid_o, done_o, busy_o}, 32'h2);
    repeat (2) @(negedge clk_i);
    chk(!ks_valid_o && done_o && !busy_o, "R8 done held", {29'h0, ks_valid_o, done_o, busy_o}, 32'h2);
  endtask

  task automatic run_zero(input logic [127:0] k, input logic [127:0] v);
    bit seen;
    @(negedge clk_i);
    key_i = k; iv_i = v; count_i = '0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    seen = 1'b0;
    for (int c = 1; c < 34; c++) begin
      if (ks_valid_o) seen = 1'b1;
      chk(!done_o, "R9 done not early", 32'(done_o), 32'h0);
      @(negedge clk_i);
    end
    chk(!seen && !ks_valid_o, "R9 no word offered", 32'(seen), 32'h0);
    chk(done_o && !busy_o, "R9 done after 34 edges", {30'h0, done_o, busy_o}, 32'h2);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'h5eed_0077));
    rst_ni = 1'b0; start_i = 1'b0; key_i = '0; iv_i = '0; count_i = '0; ks_ready_i = 1'b0;
    build_tables();
    // model sanity against known box entries (R4)
    chk(t_sr[8'h01] == 8'h7c, "R4 model box r", 32'(t_sr[8'h01]), 32'h7c);
    chk(t_sr[8'h53] == 8'hed, "R4 model box r", 32'(t_sr[8'h53]), 32'hed);
    chk(t_sq[8'h02] == 8'h73, "R4 model box q", 32'(t_sq[8'h02]), 32'h73);
    chk(t_sq[8'hff] == 8'h86, "R4 model box q", 32'(t_sq[8'hff]), 32'h86);
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !ks_valid_o, "R1 reset state", {29'h0, busy_o, done_o, ks_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !ks_valid_o, "R1 after release", {29'h0, busy_o, done_o, ks_valid_o}, 32'h0);

    run_case('0, '0, 8, 1'b0, 1'b0);
    run_case({4{32'hffff_ffff}}, {32'h0, 32'h1, 32'h2, 32'h3}, 8, 1'b0, 1'b0);
    for (int t = 0; t < 6; t++) run_case(rnd128(), rnd128(), 8, 1'b1, 1'b0);
    run_case(rnd128(), rnd128(), 100, 1'b1, 1'b0);
    run_zero(rnd128(), rnd128());
    run_case(rnd128(), rnd128(), 5, 1'b1, 1'b1);
    run_case(rnd128(), rnd128(), 1, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule